// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the command front end of a parallel NOR flash device. It watches single-cycle bus write strobes (address plus data byte) and decodes two multi-write sequences from them: a four-write word program and a six-write chip erase. Each accepted operation starts an embedded engine, modelled here as a down-counter. Writes that break a sequence send the decoder back to read mode. While the engine runs, reads return a status byte instead of array contents. An erase first passes through a preprogram phase and then an erase phase. Once started, it ignores every bus write until it completes or a hardware reset cuts it short.

A running program can be suspended with data B0h at any address. The suspended state is reported only after a settle delay of `SUSP_DLY` cycles. Data 30h at any address resumes the program from where it stopped. Resume writes that arrive while programming are ignored. The bus has no back-pressure: a strobe on `wr_en` or `rd_en` is taken in the cycle it is seen, and nothing is queued. Reads are combinational on `rd_sect`/`arr_data`. A status read updates the toggle bit at the clock edge that ends the read cycle.

Top module: `nfcmd_seq`

## Requirements
- R1: Chip erase starts only after six consecutive writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h. `busy` and `erasing` are high in the cycle after the sixth write.
- R2: A write that does not match the next expected address/data returns the decoder to read mode, and no operation starts.
- R3: An erase keeps `busy` and `erasing` high for exactly `PRE_CYC` preprogram cycles plus `ERASE_CYC` erase cycles. After that, reads return `arr_data` again.
- R4: Every bus write during an erase is ignored. The erase duration is unchanged and `suspended` stays low.
- R5: A low level on `rst_n` aborts any operation at once: `busy`, `erasing` and `suspended` go low, and reads return `arr_data`.
- R6: The writes 555h/AAh, 2AAh/55h, 555h/A0h, followed by any address/data write, start a program that keeps `busy` high for `PROG_CYC` cycles of progress.
- R7: The status byte read while running has bit 7 equal to the complement of bit 7 of the program data (0 during erase). Bit 6 inverts on every consecutive status read. Bit 2 equals bit 6 during erase and is 0 during program. All other bits are 0.
- R8: Data B0h written during a program freezes its progress. `suspended` rises exactly `SUSP_DLY` cycles after that write.
- R9: While suspended, a read whose sector (address bits from `SECT_LSB` up) matches the programmed sector returns the status byte with bit 6 held still. Reads from other sectors return `arr_data`.
- R10: Data 30h while suspended resumes the program for its remaining cycles. Data 30h written while programming has no effect on the remaining time.
- R11: After a resume, a further B0h suspends the program again with the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write address |
| wr_data | input | 8 | Bus write data byte |
| rd_en | input | 1 | Bus read strobe |
| rd_sect | input | AW-SECT_LSB | Sector bits of the read address |
| arr_data | input | 8 | Byte from the cell array for the current read |
| rd_data | output | 8 | Read data: array byte or status byte |
| busy | output | 1 | An embedded operation is in progress or suspended |
| suspended | output | 1 | The program suspend has settled |
| erasing | output | 1 | Chip erase is in its preprogram or erase phase |

## Verification
The hardest state to reach from the ports is a second suspend on a program that has already been suspended and resumed once. Checking its exact remaining duration requires counting how many progress cycles ran in each active window. The bench starts a program, waits a known number of cycles, and suspends it. It waits out the settle delay, reads both sectors, and resumes. It then repeats the suspend after a second known gap. It counts the cycles until `busy` falls and compares them with the program length minus the progress already spent, which shows that the settle and suspended cycles consumed none.

// File: rtl/nfcmd_pkg.sv
`timescale 1ns/1ps
package nfcmd_pkg;
  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_SWAIT, E_SUSP, E_PRE, E_ERASE
  } eng_st_t;

  typedef enum logic [2:0] {
    D_READ, D_U1, D_U2, D_PSET, D_ESET, D_EU1, D_EU2
  } dec_st_t;

  localparam logic [7:0] K_UNLK1 = 8'hAA;
  localparam logic [7:0] K_UNLK2 = 8'h55;
  localparam logic [7:0] K_ESET  = 8'h80;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_PGM   = 8'hA0;
  localparam logic [7:0] K_SUSP  = 8'hB0;
  localparam logic [7:0] K_RES   = 8'h30;
endpackage

// File: rtl/nfcmd_decode.sv
`timescale 1ns/1ps
module nfcmd_decode
  import nfcmd_pkg::*;
#(
  parameter int AW = 12,
  parameter int SECT_LSB = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   eng_idle,
  output logic                   go_prog,
  output logic                   go_erase,
  output logic [AW-SECT_LSB-1:0] go_sect,
  output logic                   go_msb
);
  localparam logic [AW-1:0] ADDR_A = AW'(12'h555);
  localparam logic [AW-1:0] ADDR_B = AW'(12'h2AA);

  dec_st_t st_q, st_d;
  logic    hit_a, hit_b;

  always_comb begin
    hit_a = (wr_addr == ADDR_A) && (wr_data == K_UNLK1);
    hit_b = (wr_addr == ADDR_B) && (wr_data == K_UNLK2);
  end

  always_comb begin
    st_d     = st_q;
    go_prog  = 1'b0;
    go_erase = 1'b0;
    if (!eng_idle) begin
      st_d = D_READ;
    end else if (wr_en) begin
      unique case (st_q)
        D_READ: st_d = hit_a ? D_U1 : D_READ;
        D_U1:   st_d = hit_b ? D_U2 : D_READ;
        D_U2: begin
          if (wr_addr == ADDR_A && wr_data == K_PGM)       st_d = D_PSET;
          else if (wr_addr == ADDR_A && wr_data == K_ESET) st_d = D_ESET;
          else                                             st_d = D_READ;
        end
        D_PSET: begin
          go_prog = 1'b1;
          st_d    = D_READ;
        end
        D_ESET: st_d = hit_a ? D_EU1 : D_READ;
        D_EU1:  st_d = hit_b ? D_EU2 : D_READ;
        D_EU2: begin
          go_erase = (wr_addr == ADDR_A) && (wr_data == K_CHIP);
          st_d     = D_READ;
        end
        default: st_d = D_READ;
      endcase
    end
  end

  assign go_sect = wr_addr[AW-1:SECT_LSB];
  assign go_msb  = wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= D_READ;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/nfcmd_engine.sv
`timescale 1ns/1ps
module nfcmd_engine
  import nfcmd_pkg::*;
#(
  parameter int SB = 4,
  parameter int PROG_CYC = 40,
  parameter int PRE_CYC = 30,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_DLY = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          go_prog,
  input  logic          go_erase,
  input  logic [SB-1:0] go_sect,
  input  logic          go_msb,
  output eng_st_t       st,
  output logic [SB-1:0] sect_q,
  output logic          msb_q
);
  localparam int M1   = (PROG_CYC > PRE_CYC) ? PROG_CYC : PRE_CYC;
  localparam int CMAX = (M1 > ERASE_CYC) ? M1 : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int DW   = $clog2(SUSP_DLY + 1);

  eng_st_t       st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dly_q;
  logic          is_susp, is_res;

  assign is_susp = wr_en && (wr_data == K_SUSP);
  assign is_res  = wr_en && (wr_data == K_RES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      dly_q  <= '0;
      sect_q <= '0;
      msb_q  <= 1'b0;
    end else begin
      unique case (st_q)
        E_IDLE: begin
          if (go_prog) begin
            st_q   <= E_PROG;
            cnt_q  <= CW'(PROG_CYC - 1);
            sect_q <= go_sect;
            msb_q  <= go_msb;
          end else if (go_erase) begin
            st_q  <= E_PRE;
            cnt_q <= CW'(PRE_CYC - 1);
          end
        end
        E_PROG: begin
          if (is_susp) begin
            st_q  <= E_SWAIT;
            dly_q <= DW'(SUSP_DLY - 1);
          end else if (cnt_q == '0) begin
            st_q   <= E_IDLE;
            sect_q <= '0;
            msb_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        E_SWAIT: begin
          if (dly_q == '0) st_q  <= E_SUSP;
          else             dly_q <= dly_q - 1'b1;
        end
        E_SUSP: begin
          if (is_res) st_q <= E_PROG;
        end
        E_PRE: begin
          if (cnt_q == '0) begin
            st_q  <= E_ERASE;
            cnt_q <= CW'(ERASE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        E_ERASE: begin
          if (cnt_q == '0) st_q  <= E_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign st = st_q;
endmodule

// File: rtl/nfcmd_status.sv
`timescale 1ns/1ps
module nfcmd_status
  import nfcmd_pkg::*;
#(
  parameter int SB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  eng_st_t       st,
  input  logic [SB-1:0] sect_q,
  input  logic          msb_q,
  input  logic          rd_en,
  input  logic [SB-1:0] rd_sect,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rd_data
);
  logic run_rd, er_rd, tgl_q;

  assign run_rd = (st == E_PROG) || (st == E_SWAIT) || (st == E_PRE) || (st == E_ERASE);
  assign er_rd  = (st == E_PRE) || (st == E_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tgl_q <= 1'b0;
    else if (rd_en && run_rd) tgl_q <= ~tgl_q;
  end

  always_comb begin
    rd_data = arr_data;
    if (run_rd)
      rd_data = {(er_rd ? 1'b0 : ~msb_q), tgl_q, 3'b000, (er_rd & tgl_q), 2'b00};
    else if (st == E_SUSP && rd_sect == sect_q)
      rd_data = {~msb_q, tgl_q, 6'b000000};
  end
endmodule

// File: rtl/nfcmd_seq.sv
`timescale 1ns/1ps
module nfcmd_seq
  import nfcmd_pkg::*;
#(
  parameter int AW = 12,
  parameter int SECT_LSB = 8,
  parameter int PROG_CYC = 40,
  parameter int PRE_CYC = 30,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_DLY = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   rd_en,
  input  logic [AW-SECT_LSB-1:0] rd_sect,
  input  logic [7:0]             arr_data,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic                   suspended,
  output logic                   erasing
);
  localparam int SB = AW - SECT_LSB;

  eng_st_t       st;
  logic          go_prog, go_erase, go_msb, msb_q;
  logic [SB-1:0] go_sect, sect_q;

  nfcmd_decode #(.AW(AW), .SECT_LSB(SECT_LSB)) dec_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_idle(st == E_IDLE), .go_prog(go_prog),
    .go_erase(go_erase), .go_sect(go_sect), .go_msb(go_msb)
  );

  nfcmd_engine #(
    .SB(SB), .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC),
    .ERASE_CYC(ERASE_CYC), .SUSP_DLY(SUSP_DLY)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .go_prog(go_prog), .go_erase(go_erase), .go_sect(go_sect),
    .go_msb(go_msb), .st(st), .sect_q(sect_q), .msb_q(msb_q)
  );

  nfcmd_status #(.SB(SB)) sts_i (
    .clk(clk), .rst_n(rst_n), .st(st), .sect_q(sect_q), .msb_q(msb_q),
    .rd_en(rd_en), .rd_sect(rd_sect), .arr_data(arr_data), .rd_data(rd_data)
  );

  assign busy      = (st != E_IDLE);
  assign suspended = (st == E_SUSP);
  assign erasing   = (st == E_PRE) || (st == E_ERASE);
endmodule

// File: rtl/nfcmd_seq_chk.sv
`timescale 1ns/1ps
module nfcmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       suspended,
  input logic       erasing
);
  a_r8_susp_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> busy);

  a_r4_no_susp_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> !suspended);

  a_r3_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erasing |-> busy);

  a_r1_erase_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erasing) |-> ($past(wr_en) && $past(wr_data) == 8'h10));

  a_r10_resume_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(suspended) && busy) |-> ($past(wr_en) && $past(wr_data) == 8'h30));

  a_r7_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !suspended && rd_en) |-> (rd_data[5:3] == 3'b000 && rd_data[1:0] == 2'b00));
endmodule

bind nfcmd_seq nfcmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
  .suspended(suspended), .erasing(erasing)
);

// File: tb/nfcmd_seq_tb_top.sv
`timescale 1ns/1ps
module nfcmd_seq_tb_top;
  localparam int CLK_NS    = 10;
  localparam int AW        = 12;
  localparam int SECT_LSB  = 8;
  localparam int PROG_CYC  = 40;
  localparam int PRE_CYC   = 30;
  localparam int ERASE_CYC = 60;
  localparam int SUSP_DLY  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-SECT_LSB-1:0] rd_sect = '0;
  logic [7:0] arr_data;
  logic [7:0] rd_data;
  logic busy, suspended, erasing;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  assign arr_data = {4'hC, rd_sect} ^ 8'h3C;

  always #(CLK_NS/2) clk = ~clk;

  nfcmd_seq #(
    .AW(AW), .SECT_LSB(SECT_LSB), .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC),
    .ERASE_CYC(ERASE_CYC), .SUSP_DLY(SUSP_DLY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sect(rd_sect), .arr_data(arr_data),
    .rd_data(rd_data), .busy(busy), .suspended(suspended), .erasing(erasing)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-SECT_LSB-1:0] s, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_sect = s;
    #1 d = rd_data;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic erase_seq();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
  endtask

  task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic count_busy(output int n, output bit sus_seen);
    n = 0; sus_seen = 1'b0;
    while (busy === 1'b1 && n < 2000) begin
      @(posedge clk); #1;
      n++;
      if (suspended === 1'b1) sus_seen = 1'b1;
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    hw_reset();
    chk("R5 busy after reset", busy, 0);
    chk("R5 suspended after reset", suspended, 0);
    chk("R5 erasing after reset", erasing, 0);
    rd(4'h7, d);
    chk("R5 array read after reset", d, 8'hC7 ^ 8'h3C);
  endtask

  task automatic t_erase_full();
    logic [7:0] r1, r2, d;
    int n; bit s;
    erase_seq();
    chk("R1 busy after sixth write", busy, 1);
    chk("R1 erasing after sixth write", erasing, 1);
    rd(4'h2, r1); rd(4'h2, r2);
    chk("R7 erase status first", r1, {1'b0, r1[6], 3'b000, r1[6], 2'b00});
    chk("R7 erase status second", r2, {1'b0, ~r1[6], 3'b000, ~r1[6], 2'b00});
    count_busy(n, s);
    chk("R3 erase duration", n, PRE_CYC + ERASE_CYC - 2);
    chk("R3 erasing low at end", erasing, 0);
    rd(4'h5, d);
    chk("R3 array read after erase", d, 8'hC5 ^ 8'h3C);
  endtask

  task automatic t_erase_ignore();
    int n; bit s;
    erase_seq();
    wr(12'h123, 8'hB0); wr(12'h456, 8'h30);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    count_busy(n, s);
    chk("R4 erase duration with writes", n, PRE_CYC + ERASE_CYC - 4);
    chk("R4 no suspend during erase", s, 0);
  endtask

  task automatic t_mismatch();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h20);
    idle(2);
    chk("R2 wrong final data", busy, 0);
    wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
    idle(2);
    chk("R2 wrong second address", busy, 0);
    erase_seq();
    chk("R2 clean sequence after mismatch", erasing, 1);
    hw_reset();
  endtask

  task automatic t_hw_abort();
    logic [7:0] d;
    erase_seq();
    idle(20);
    chk("R5 erase running before reset", erasing, 1);
    hw_reset();
    chk("R5 busy cleared by reset", busy, 0);
    chk("R5 erasing cleared by reset", erasing, 0);
    rd(4'h9, d);
    chk("R5 array read after abort", d, 8'hC9 ^ 8'h3C);
  endtask

  task automatic t_program();
    logic [7:0] r1, r2;
    int n; bit s;
    prog_seq(12'h312, 8'h3C);
    chk("R6 busy after program write", busy, 1);
    rd(4'h1, r1); rd(4'h1, r2);
    chk("R7 program status first", r1, {1'b1, r1[6], 6'b000000});
    chk("R7 program status second", r2, {1'b1, ~r1[6], 6'b000000});
    count_busy(n, s);
    chk("R6 program duration", n, PROG_CYC - 2);
  endtask

  task automatic t_suspend_resume();
    logic [7:0] a, b, c;
    int n; bit s;
    prog_seq(12'h3A0, 8'h81);
    idle(10);
    wr(12'h7FF, 8'hB0);
    idle(SUSP_DLY - 1);
    chk("R8 not suspended before delay", suspended, 0);
    idle(1);
    chk("R8 suspended after delay", suspended, 1);
    rd(4'h3, a); rd(4'h3, b);
    chk("R9 suspended sector status", a, {1'b0, a[6], 6'b000000});
    chk("R9 suspended sector bit6 held", b, a);
    rd(4'h1, c);
    chk("R9 other sector array", c, 8'hC1 ^ 8'h3C);
    wr(12'h000, 8'h30);
    chk("R10 resumed", suspended, 0);
    wr(12'h000, 8'h30);
    chk("R10 second resume keeps running", busy, 1);
    count_busy(n, s);
    chk("R10 remaining program time", n, PROG_CYC - 10 - 1);
  endtask

  task automatic t_resuspend();
    int n; bit s;
    prog_seq(12'h2C4, 8'h11);
    idle(5);
    wr(12'h001, 8'hB0);
    idle(SUSP_DLY);
    chk("R8 first suspend", suspended, 1);
    wr(12'h002, 8'h30);
    idle(3);
    wr(12'h003, 8'hB0);
    idle(SUSP_DLY);
    chk("R11 second suspend accepted", suspended, 1);
    wr(12'h004, 8'h30);
    count_busy(n, s);
    chk("R11 remaining after two suspends", n, PROG_CYC - 8);
  endtask

  initial begin
    hw_reset();
    t_reset_state();
    t_erase_full();
    t_erase_ignore();
    t_mismatch();
    t_hw_abort();
    t_program();
    t_suspend_resume();
    t_resuspend();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule